// File: doc/BRIEF.md
# Clocked Serial Byte Receiver

This block takes 8-bit bytes from a clocked serial line, shifting each one in with the most significant bit first. The shift clock can be made inside the block by dividing the system clock, in which case the block drives it out to the sender. It can also come from the sender, in which case the block passes it through a two-flop synchronizer and detects its rising edges. A data bit is sampled on each rising shift-clock edge. After the eighth bit the byte moves into a receive buffer, a buffer-full flag rises and the block pulses an interrupt request.

Software arms the receiver with a run control and reads bytes with a buffer read strobe. Overrun is handled according to the clock source. With the internal clock, the block holds the shift clock idle-high and does not start a new byte while the buffer is still full. With an external clock, a byte that completes while the buffer is full sets a sticky receive-error flag and is discarded. There are two ways to stop. Clearing the run control lets the current byte finish. Raising the inhibit input aborts at once and clears all state.

Top module: `sync_rx_ctrl`

## Requirements
- R1: Bytes are assembled most significant bit first: the first bit sampled lands in `rx_data[7]` and the eighth in `rx_data[0]`.
- R2: With the internal clock, each low phase and each high phase of `sck_out` lasts `div_sel`+1 system clock cycles. `sck_out` is high whenever no byte is being shifted.
- R3: With the internal clock, no new byte starts while `buf_full` is 1. `sck_out` stays high and the buffer keeps its byte until it is read.
- R4: A completed byte sets `buf_full` and loads `rx_data`. A `buf_rd` strobe clears `buf_full`.
- R5: With the external clock, a byte that completes while `buf_full` is 1 and `buf_rd` is not asserted sets `rx_err`. `rx_data` keeps the earlier byte and `buf_full` stays 1.
- R6: `irq` is a single-cycle pulse, given once for each completed byte, including an erroneous one. In the cycle it is high, `buf_full` or `rx_err` is already 1.
- R7: `rx_err` is sticky. A `buf_rd` alone does not clear it. It is cleared by a `stat_rd` strobe while `rx_err` is 1, followed later by a `buf_rd`.
- R8: Clearing the run control (`run_clr`) during a byte does not abort it. The byte is received, `busy` then drops to 0, and no further byte starts.
- R9: With the external clock, shift-clock edges that arrive while the run control is clear and no byte is in progress are ignored: no bits are taken, no byte completes, no `irq`.
- R10: While `inhibit` is 1, the next clock edge clears the run control, `shifting`, `buf_full`, `rx_err` and `rx_data`, and any partial byte is dropped.
- R11: `shifting` rises on the first shift-clock edge of a byte and stays 1 until the eighth rising edge has been taken, then falls.
- R12: After reset, `busy`, `shifting`, `buf_full`, `rx_err` and `irq` are 0, `rx_data` is 0 and `sck_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_set | input | 1 | Strobe that sets the run control |
| run_clr | input | 1 | Strobe that clears the run control (graceful stop), takes priority over run_set |
| inhibit | input | 1 | Immediate abort and clear of all state |
| ext_sel | input | 1 | 1 selects the external shift clock, 0 the internal divider |
| div_sel | input | 4 | Internal half-period select, half period = div_sel+1 cycles |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Internal shift clock, idle high |
| sdi | input | 1 | Serial data input |
| buf_rd | input | 1 | Receive buffer read strobe |
| stat_rd | input | 1 | Status read strobe, arms clearing of the error flag |
| rx_data | output | 8 | Receive buffer |
| busy | output | 1 | Run control set or byte in progress |
| shifting | output | 1 | Byte shift in progress |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| rx_err | output | 1 | Overrun error flag |
| irq | output | 1 | Interrupt request pulse |

## Verification
The embedded assertions are checked on every cycle. They cover the idle-high shift clock, the automatic wait that keeps a new internal-clock byte from starting over a full buffer, the rule that no byte starts without the run control, the single-cycle interrupt that only follows a set flag, the sticky error flag and the full clear on inhibit. Only the bench scenarios can show the bit order of assembled bytes and the measured half period of the divider. They also show that the buffer keeps the earlier byte on an overrun, that a graceful stop lets the current byte complete while an inhibit drops it, and that the error flag clears only through the status-then-buffer read sequence.

// File: rtl/sync_rx_ctrl.sv
module sync_rx_ctrl #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_set,
  input  logic              run_clr,
  input  logic              inhibit,
  input  logic              ext_sel,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic              sck_in,
  output logic              sck_out,
  input  logic              sdi,
  input  logic              buf_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              shifting,
  output logic              buf_full,
  output logic              rx_err,
  output logic              irq
);
  localparam int CNT_W = $clog2(DATA_W);

  logic              run_q, err_armed;
  logic [SEL_W-1:0]  div_cnt;
  logic [2:0]        sck_sync;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shift_q;

  wire tick       = (div_cnt == div_sel);
  wire ext_rise   = sck_sync[1] & ~sck_sync[2];
  wire int_start  = !ext_sel && !shifting && run_q && !buf_full && tick;
  wire int_sample = !ext_sel && shifting && tick && !sck_out;
  wire ext_start  = ext_sel && !shifting && run_q && ext_rise;
  wire ext_sample = ext_sel && shifting && ext_rise;
  wire take_bit   = int_sample | ext_start | ext_sample;
  wire byte_done  = take_bit && (bit_cnt == CNT_W'(DATA_W-1));
  wire overrun    = byte_done && buf_full && !buf_rd;
  wire [DATA_W-1:0] next_byte = {shift_q[DATA_W-2:0], sdi};

  assign busy = run_q | shifting;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          div_cnt <= '0;
    else if (inhibit || ext_sel || tick) div_cnt <= '0;
    else                                 div_cnt <= div_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_sync <= 3'b111;
    else        sck_sync <= {sck_sync[1:0], sck_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        run_q <= 1'b0;
    else if (inhibit)  run_q <= 1'b0;
    else if (run_clr)  run_q <= 1'b0;
    else if (run_set)  run_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shifting <= 1'b0;
      sck_out  <= 1'b1;
      bit_cnt  <= '0;
      shift_q  <= '0;
    end else if (inhibit) begin
      shifting <= 1'b0;
      sck_out  <= 1'b1;
      bit_cnt  <= '0;
      shift_q  <= '0;
    end else begin
      if (byte_done)                    shifting <= 1'b0;
      else if (int_start || ext_start)  shifting <= 1'b1;
      if (ext_sel)                      sck_out <= 1'b1;
      else if (int_start)               sck_out <= 1'b0;
      else if (shifting && tick)        sck_out <= ~sck_out;
      if (byte_done)                    bit_cnt <= '0;
      else if (take_bit)                bit_cnt <= bit_cnt + 1'b1;
      if (take_bit)                     shift_q <= next_byte;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      buf_full  <= 1'b0;
      rx_data   <= '0;
      rx_err    <= 1'b0;
      err_armed <= 1'b0;
      irq       <= 1'b0;
    end else if (inhibit) begin
      buf_full  <= 1'b0;
      rx_data   <= '0;
      rx_err    <= 1'b0;
      err_armed <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= byte_done;
      if (byte_done)   buf_full <= 1'b1;
      else if (buf_rd) buf_full <= 1'b0;
      if (byte_done && !overrun) rx_data <= next_byte;
      if (overrun)                    rx_err <= 1'b1;
      else if (buf_rd && err_armed)   rx_err <= 1'b0;
      if (buf_rd || overrun)          err_armed <= 1'b0;
      else if (stat_rd && rx_err)     err_armed <= 1'b1;
    end

  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |-> sck_out);

  p_auto_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && buf_full && !shifting) |=> !shifting);

  p_full_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> irq);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (buf_full || rx_err));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !buf_rd && !inhibit) |=> rx_err);

  p_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !shifting) |=> !shifting);

  p_inhibit_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (!busy && !buf_full && !rx_err && rx_data == '0));
endmodule

// File: tb/sync_rx_ctrl_tb_top.sv
module sync_rx_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run_set = 0, run_clr = 0, inhibit = 0, ext_sel = 0;
  logic [3:0] div_sel = 4'd2;
  logic sck_ext = 1'b1, sdi_int = 0, sdi_ext = 0, buf_rd = 0, stat_rd = 0;
  logic sck_out, busy, shifting, buf_full, rx_err, irq;
  logic [7:0] rx_data;
  wire sdi = ext_sel ? sdi_ext : sdi_int;

  int checks = 0, errors = 0;
  logic [8:0] exp_q[$];
  logic       bitq[$];
  logic       prev_sck = 1'b1;

  always #10 clk = ~clk;

  sync_rx_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .run_set(run_set), .run_clr(run_clr),
    .inhibit(inhibit), .ext_sel(ext_sel), .div_sel(div_sel),
    .sck_in(sck_ext), .sck_out(sck_out), .sdi(sdi), .buf_rd(buf_rd),
    .stat_rd(stat_rd), .rx_data(rx_data), .busy(busy), .shifting(shifting),
    .buf_full(buf_full), .rx_err(rx_err), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0;
  endtask

  task automatic queue_int(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bitq.push_back(b[i]);
    exp_q.push_back({1'b0, b});
  endtask

  task automatic send_ext(input logic [7:0] b, input int from, input int to, input bit chk_sh);
    for (int i = from; i < to; i++) begin
      sdi_ext = b[7-i]; sck_ext = 1'b0; cyc(4);
      sck_ext = 1'b1; cyc(4);
      if (chk_sh) chk("R11 shifting", 32'(shifting), 32'(i < 7));
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) cyc(1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // responder: next bit after each falling internal clock edge
  always @(negedge clk) begin
    if (prev_sck && !sck_out && bitq.size() > 0) sdi_int = bitq.pop_front();
    prev_sck = sck_out;
  end

  // monitor: compare each interrupt against the scoreboard
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (exp_q.size() == 0) chk("R6 unexpected irq", 32'd1, 32'd0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk("R1 rx_data", 32'(rx_data), 32'(e[7:0]));
        chk("R5 rx_err", 32'(rx_err), 32'(e[8]));
        chk("R4 buf_full", 32'(buf_full), 32'd1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    summary();
  end

  initial begin
    int cnt;
    cyc(3); rst_n = 1'b1; cyc(1);
    chk("R12 busy", 32'(busy), 0);
    chk("R12 shifting", 32'(shifting), 0);
    chk("R12 buf_full", 32'(buf_full), 0);
    chk("R12 rx_err", 32'(rx_err), 0);
    chk("R12 irq", 32'(irq), 0);
    chk("R12 rx_data", 32'(rx_data), 0);
    chk("R12 sck_out", 32'(sck_out), 1);

    // internal clock, two bytes, automatic wait
    queue_int(8'hA5); queue_int(8'h3C);
    strobe(run_set);
    while (sck_out) cyc(1);
    cnt = 0;
    while (!sck_out) begin cnt++; cyc(1); end
    chk("R2 half period", 32'(cnt), 32'd3);
    while (exp_q.size() != 1) cyc(1);
    cyc(60);
    chk("R3 sck idle", 32'(sck_out), 1);
    chk("R3 no shift", 32'(shifting), 0);
    chk("R3 data held", 32'(rx_data), 'hA5);
    chk("R3 no error", 32'(rx_err), 0);
    strobe(buf_rd);
    chk("R4 read clears full", 32'(buf_full), 0);
    drain();
    strobe(run_clr); cyc(2);
    chk("R8 busy after stop", 32'(busy), 0);
    strobe(buf_rd); cyc(40);
    chk("R8 no new byte", 32'(shifting), 0);
    chk("R2 sck idle high", 32'(sck_out), 1);

    // graceful stop mid-byte, internal clock
    div_sel = 4'd0;
    queue_int(8'h81);
    strobe(run_set);
    while (!shifting) cyc(1);
    strobe(run_clr);
    chk("R8 busy during byte", 32'(busy), 1);
    drain(); cyc(2);
    chk("R8 busy dropped", 32'(busy), 0);
    chk("R8 byte kept", 32'(rx_data), 'h81);
    cyc(30);
    chk("R8 stays idle", 32'(shifting), 0);
    strobe(buf_rd);

    // external clock, shifting window and overrun
    ext_sel = 1'b1; cyc(2);
    strobe(run_set);
    chk("R11 idle before edge", 32'(shifting), 0);
    exp_q.push_back({1'b0, 8'h5A});
    send_ext(8'h5A, 0, 8, 1'b1);
    cyc(2);
    chk("R4 full after byte", 32'(buf_full), 1);
    exp_q.push_back({1'b1, 8'h5A});
    send_ext(8'hC3, 0, 8, 1'b0);
    cyc(2);
    chk("R5 old data kept", 32'(rx_data), 'h5A);
    chk("R5 error set", 32'(rx_err), 1);
    chk("R5 still full", 32'(buf_full), 1);

    strobe(buf_rd);
    chk("R7 read alone keeps error", 32'(rx_err), 1);
    chk("R7 buffer freed", 32'(buf_full), 0);
    strobe(stat_rd); cyc(1);
    strobe(buf_rd);
    chk("R7 error cleared", 32'(rx_err), 0);

    // edges while stopped are ignored
    strobe(run_clr);
    send_ext(8'hF0, 0, 8, 1'b0);
    cyc(2);
    chk("R9 no byte", 32'(buf_full), 0);
    chk("R9 no shift", 32'(shifting), 0);
    chk("R9 idle", 32'(busy), 0);

    // late clear after first edge: byte completes
    strobe(run_set);
    exp_q.push_back({1'b0, 8'h96});
    send_ext(8'h96, 0, 1, 1'b0);
    strobe(run_clr);
    send_ext(8'h96, 1, 8, 1'b0);
    cyc(2);
    chk("R8 late clear byte", 32'(rx_data), 'h96);
    chk("R8 busy dropped ext", 32'(busy), 0);
    strobe(buf_rd);

    // inhibit aborts and clears
    strobe(run_set);
    exp_q.push_back({1'b0, 8'h3E});
    send_ext(8'h3E, 0, 8, 1'b0);
    send_ext(8'h11, 0, 4, 1'b0);
    inhibit = 1'b1; cyc(1); inhibit = 1'b0;
    chk("R10 busy", 32'(busy), 0);
    chk("R10 shifting", 32'(shifting), 0);
    chk("R10 buf_full", 32'(buf_full), 0);
    chk("R10 rx_err", 32'(rx_err), 0);
    chk("R10 rx_data", 32'(rx_data), 0);
    send_ext(8'h11, 4, 8, 1'b0);
    cyc(2);
    chk("R10 partial dropped", 32'(buf_full), 0);
    chk("R6 all bytes seen", 32'(exp_q.size()), 0);
    summary();
  end
endmodule